// File: doc/BRIEF.md
# Interrupt destination resolver

This block turns one interrupt command into the set of agents that must act on it, and states what each of those agents has to do. The command is held in two 32-bit words. The upper word carries the destination byte and is stored when it is written. A write of the lower word starts a resolution, and that resolution uses the stored upper word. If the upper word is written in the same cycle, the new value is used.

Each agent is described by four inputs: a populated flag, a physical ID, a logical ID and a logical model nibble. The destination can be chosen in three ways: by a shorthand, by physical ID, or by logical matching in the flat or cluster model. Lowest-priority delivery reduces the set to one agent. The result is a target mask plus one action mask per kind of delivery. All of these appear for a single cycle, marked by a valid pulse.

Top module: `irq_dest_resolver`

## Requirements
- R1: With shorthand 0 and destination-mode bit 0 (physical), a destination of 0xFF selects every populated agent. Any other destination selects only the lowest-indexed populated agent whose physical ID equals it, and no agent if none is equal.
- R2: With shorthand 0 and destination-mode bit 1 (logical), an agent of model 0xF (flat) is selected when the destination AND its logical ID is non-zero.
- R3: In logical mode, an agent of model 0x0 (cluster) is selected when the upper nibbles of the destination and of its logical ID are equal and the AND of their lower nibbles is non-zero. An agent of any other model is never selected logically.
- R4: Shorthand 1 selects only the sender. Shorthand 2 selects all populated agents. Shorthand 3 selects all populated agents except the sender. A shorthand other than 0 ignores the destination byte.
- R5: The lower word holds the vector in bits 7:0, the delivery mode in 10:8, the destination mode in 11, the level in 14, the trigger in 15 and the shorthand in 19:18. The destination is in bits 31:24 of the upper word. res_vector, res_mode and res_trigger report the vector, delivery mode and trigger of the resolved command.
- R6: Delivery mode 001 (lowest priority) keeps only the lowest-indexed agent of the selected set, and that agent posts the vector through fixed_mask.
- R7: Delivery mode 101 with level 0 and trigger 1 raises only arbsync_mask over the targets. Every other combination of mode 101 raises init_mask.
- R8: Mode 000 raises fixed_mask, 010 raises smi_mask, 100 raises nmi_mask and 110 raises startup_mask, each equal to target_mask. At most one action mask is non-zero.
- R9: Modes 011 and 111 are dropped: target_mask still reports the set, and every action mask is zero.
- R10: An agent whose populated flag is 0 is never selected, whichever path (including the sender) would otherwise select it.
- R11: res_valid is high in exactly the cycle after a lower-word write. All result outputs are zero whenever res_valid is low.
- R12: After reset, res_valid and all masks are zero and the stored destination is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_hi_we | input | 1 | Store the upper command word |
| cmd_hi | input | 32 | Upper command word, destination in 31:24 |
| cmd_lo_we | input | 1 | Write the lower command word and resolve |
| cmd_lo | input | 32 | Lower command word |
| sender_id | input | 8 | Index of the issuing agent |
| agent_present | input | N | Populated flag per agent |
| agent_phys_id | input | 8*N | Physical ID per agent |
| agent_log_id | input | 8*N | Logical ID per agent |
| agent_model | input | 4*N | Logical model per agent |
| res_valid | output | 1 | One-cycle result strobe |
| res_vector | output | 8 | Vector of the resolved command |
| res_mode | output | 3 | Delivery mode of the resolved command |
| res_trigger | output | 1 | Trigger bit of the resolved command |
| target_mask | output | N | Resolved target set |
| fixed_mask | output | N | Agents posting the vector |
| smi_mask | output | N | Agents receiving SMI |
| nmi_mask | output | N | Agents receiving NMI |
| init_mask | output | N | Agents receiving INIT |
| startup_mask | output | N | Agents recording a startup vector |
| arbsync_mask | output | N | Agents copying physical ID into arbitration ID |

## Verification
Every result is registered once. It is therefore due in the cycle that follows the clock edge capturing the lower-word write, and it is gone one cycle later. The bench drives inputs on falling edges, pulses the write for one cycle, and samples on the next falling edge, when res_valid must be high. The following falling edge then checks that the pulse has ended and that the masks are back to zero. A write of the upper word alone produces no result, and the bench checks this in the cycle where a result would otherwise appear.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWEST = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSVD3  = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_RSVD7  = 3'b111
  } dmode_e;

  typedef struct packed {
    logic [7:0] vector;
    dmode_e     mode;
    logic       logical;
    logic       level;
    logic       trigger;
    logic [1:0] shorthand;
  } cmd_t;

  localparam logic [7:0] DEST_ALL      = 8'hFF;
  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;

  localparam logic [1:0] SH_NONE   = 2'd0;
  localparam logic [1:0] SH_SELF   = 2'd1;
  localparam logic [1:0] SH_ALL    = 2'd2;
  localparam logic [1:0] SH_OTHERS = 2'd3;

  function automatic cmd_t unpack_cmd(input logic [31:0] lo);
    cmd_t c;
    c.vector    = lo[7:0];
    c.mode      = dmode_e'(lo[10:8]);
    c.logical   = lo[11];
    c.level     = lo[14];
    c.trigger   = lo[15];
    c.shorthand = lo[19:18];
    return c;
  endfunction

  function automatic logic logical_hit(input logic [7:0] dest,
                                       input logic [7:0] lid,
                                       input logic [3:0] model);
    logic hit;
    if (model == MODEL_FLAT)
      hit = |(dest & lid);
    else if (model == MODEL_CLUSTER)
      hit = (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
    else
      hit = 1'b0;
    return hit;
  endfunction

  function automatic logic init_is_arbsync(input logic level, input logic trigger);
    return (!level) && trigger;
  endfunction

endpackage

// File: rtl/idr_agent_match.sv
module idr_agent_match
  import irq_dest_pkg::*;
#(
  parameter int N   = 8,
  parameter int IDW = 8
) (
  input  logic [7:0]       dest,
  input  logic             logical,
  input  logic [N-1:0]     present,
  input  logic [N*IDW-1:0] phys_ids,
  input  logic [N*8-1:0]   log_ids,
  input  logic [N*4-1:0]   models,
  output logic [N-1:0]     dest_mask
);

  logic [N-1:0] phys_hit;
  logic [N-1:0] log_hit;
  logic [N-1:0] phys_first;

  for (genvar i = 0; i < N; i++) begin : g_agent
    assign phys_hit[i] = present[i] && (phys_ids[i*IDW +: IDW] == IDW'(dest));
    assign log_hit[i]  = present[i] &&
                         logical_hit(dest, log_ids[i*8 +: 8], models[i*4 +: 4]);
  end

  assign phys_first = phys_hit & (~phys_hit + N'(1));

  always_comb begin
    if (logical)
      dest_mask = log_hit;
    else if (dest == DEST_ALL)
      dest_mask = present;
    else
      dest_mask = phys_first;
  end

endmodule

// File: rtl/idr_select.sv
module idr_select
  import irq_dest_pkg::*;
#(
  parameter int N   = 8,
  parameter int IDW = 8
) (
  input  logic [1:0]     shorthand,
  input  logic           lowest,
  input  logic [IDW-1:0] sender,
  input  logic [N-1:0]   present,
  input  logic [N-1:0]   dest_mask,
  output logic [N-1:0]   target
);

  logic [N-1:0] sender_oh;
  logic [N-1:0] chosen;

  for (genvar i = 0; i < N; i++) begin : g_snd
    assign sender_oh[i] = (sender == IDW'(i));
  end

  always_comb begin
    unique case (shorthand)
      SH_NONE:   chosen = dest_mask;
      SH_SELF:   chosen = sender_oh;
      SH_ALL:    chosen = {N{1'b1}};
      default:   chosen = ~sender_oh;
    endcase
    chosen = chosen & present;
    if (lowest)
      target = chosen & (~chosen + N'(1));
    else
      target = chosen;
  end

endmodule

// File: rtl/idr_action.sv
module idr_action
  import irq_dest_pkg::*;
#(
  parameter int N = 8
) (
  input  dmode_e       mode,
  input  logic         level,
  input  logic         trigger,
  input  logic [N-1:0] target,
  output logic [N-1:0] fixed_m,
  output logic [N-1:0] smi_m,
  output logic [N-1:0] nmi_m,
  output logic [N-1:0] init_m,
  output logic [N-1:0] start_m,
  output logic [N-1:0] arb_m
);

  always_comb begin
    fixed_m = '0;
    smi_m   = '0;
    nmi_m   = '0;
    init_m  = '0;
    start_m = '0;
    arb_m   = '0;
    case (mode)
      DM_FIXED, DM_LOWEST: fixed_m = target;
      DM_SMI:              smi_m   = target;
      DM_NMI:              nmi_m   = target;
      DM_START:            start_m = target;
      DM_INIT: begin
        if (init_is_arbsync(level, trigger)) arb_m = target;
        else                                 init_m = target;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int N   = 8,
  parameter int IDW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_hi_we,
  input  logic [31:0]      cmd_hi,
  input  logic             cmd_lo_we,
  input  logic [31:0]      cmd_lo,
  input  logic [IDW-1:0]   sender_id,
  input  logic [N-1:0]     agent_present,
  input  logic [N*IDW-1:0] agent_phys_id,
  input  logic [N*8-1:0]   agent_log_id,
  input  logic [N*4-1:0]   agent_model,
  output logic             res_valid,
  output logic [7:0]       res_vector,
  output logic [2:0]       res_mode,
  output logic             res_trigger,
  output logic [N-1:0]     target_mask,
  output logic [N-1:0]     fixed_mask,
  output logic [N-1:0]     smi_mask,
  output logic [N-1:0]     nmi_mask,
  output logic [N-1:0]     init_mask,
  output logic [N-1:0]     startup_mask,
  output logic [N-1:0]     arbsync_mask
);

  logic [7:0]   dest_q;
  logic [7:0]   dest_eff;
  cmd_t         cmd;
  logic [N-1:0] dest_mask;
  logic [N-1:0] target_nxt;
  logic [N-1:0] fix_n, smi_n, nmi_n, init_n, start_n, arb_n;
  logic         unused_cmd_bits;

  assign unused_cmd_bits = ^{cmd_hi[23:0], cmd_lo[31:20], cmd_lo[17:16], cmd_lo[13:12]};

  assign dest_eff = cmd_hi_we ? cmd_hi[31:24] : dest_q;
  assign cmd      = unpack_cmd(cmd_lo);

  always_ff @(posedge clk) begin
    if (!rst_n)         dest_q <= '0;
    else if (cmd_hi_we) dest_q <= cmd_hi[31:24];
  end

  idr_agent_match #(.N(N), .IDW(IDW)) u_match (
    .dest      (dest_eff),
    .logical   (cmd.logical),
    .present   (agent_present),
    .phys_ids  (agent_phys_id),
    .log_ids   (agent_log_id),
    .models    (agent_model),
    .dest_mask (dest_mask)
  );

  idr_select #(.N(N), .IDW(IDW)) u_select (
    .shorthand (cmd.shorthand),
    .lowest    (cmd.mode == DM_LOWEST),
    .sender    (sender_id),
    .present   (agent_present),
    .dest_mask (dest_mask),
    .target    (target_nxt)
  );

  idr_action #(.N(N)) u_action (
    .mode    (cmd.mode),
    .level   (cmd.level),
    .trigger (cmd.trigger),
    .target  (target_nxt),
    .fixed_m (fix_n),
    .smi_m   (smi_n),
    .nmi_m   (nmi_n),
    .init_m  (init_n),
    .start_m (start_n),
    .arb_m   (arb_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !cmd_lo_we) begin
      res_valid    <= 1'b0;
      res_vector   <= '0;
      res_mode     <= '0;
      res_trigger  <= 1'b0;
      target_mask  <= '0;
      fixed_mask   <= '0;
      smi_mask     <= '0;
      nmi_mask     <= '0;
      init_mask    <= '0;
      startup_mask <= '0;
      arbsync_mask <= '0;
    end else begin
      res_valid    <= 1'b1;
      res_vector   <= cmd.vector;
      res_mode     <= cmd.mode;
      res_trigger  <= cmd.trigger;
      target_mask  <= target_nxt;
      fixed_mask   <= fix_n;
      smi_mask     <= smi_n;
      nmi_mask     <= nmi_n;
      init_mask    <= init_n;
      startup_mask <= start_n;
      arbsync_mask <= arb_n;
    end
  end

endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk
  import irq_dest_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_lo_we,
  input logic [N-1:0] agent_present,
  input logic         res_valid,
  input logic [2:0]   res_mode,
  input logic [N-1:0] target_mask,
  input logic [N-1:0] fixed_mask,
  input logic [N-1:0] smi_mask,
  input logic [N-1:0] nmi_mask,
  input logic [N-1:0] init_mask,
  input logic [N-1:0] startup_mask,
  input logic [N-1:0] arbsync_mask
);

  logic [N-1:0] any_action;
  assign any_action = fixed_mask | smi_mask | nmi_mask | init_mask | startup_mask | arbsync_mask;

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_lo_we) |-> res_valid);

  assert_nopulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_lo_we) |-> !res_valid);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (target_mask == '0 && any_action == '0));

  assert_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_action & ~target_mask) == '0);

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|fixed_mask, |smi_mask, |nmi_mask, |init_mask, |startup_mask, |arbsync_mask}));

  assert_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mode == DM_LOWEST) |-> $onehot0(target_mask));

  assert_arbsync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|arbsync_mask) |-> (res_mode == DM_INIT));

  assert_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_mode == DM_RSVD3 || res_mode == DM_RSVD7) |-> any_action == '0);

  assert_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (target_mask & ~$past(agent_present)) == '0);

endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.N(N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_lo_we    (cmd_lo_we),
  .agent_present(agent_present),
  .res_valid    (res_valid),
  .res_mode     (res_mode),
  .target_mask  (target_mask),
  .fixed_mask   (fixed_mask),
  .smi_mask     (smi_mask),
  .nmi_mask     (nmi_mask),
  .init_mask    (init_mask),
  .startup_mask (startup_mask),
  .arbsync_mask (arbsync_mask)
);

// File: tb/irq_dest_resolver_tb.sv
module irq_dest_resolver_tb;

  localparam int N = 8;

  localparam logic [2:0] A_FIX = 3'd0, A_SMI = 3'd1, A_NMI = 3'd2, A_INIT = 3'd3,
                         A_START = 3'd4, A_ARB = 3'd5, A_NONE = 3'd6;

  typedef struct packed {
    logic [31:0] lo;
    logic [7:0]  dest;
    logic [7:0]  snd;
    logic [7:0]  mask;
    logic [2:0]  act;
  } vec_t;

  // lower word: sh[19:18] trig[15] lvl[14] dm[11] mode[10:8] vec[7:0]
  function automatic logic [31:0] mk_lo(input logic [1:0] sh, input logic trig,
                                        input logic lvl, input logic dm,
                                        input logic [2:0] mode, input logic [7:0] vec);
    return {12'b0, sh, 2'b0, trig, lvl, 2'b0, dm, mode, vec};
  endfunction

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{mk_lo(0,0,0,0,3'd0,8'h40), 8'h12, 8'd0, 8'h04, A_FIX},   // 0  R1 exact
    '{mk_lo(0,0,0,0,3'd0,8'h41), 8'hFF, 8'd0, 8'h7F, A_FIX},   // 1  R1 broadcast
    '{mk_lo(0,0,0,0,3'd0,8'h42), 8'h55, 8'd0, 8'h00, A_FIX},   // 2  R1 none
    '{mk_lo(0,0,0,0,3'd0,8'h43), 8'h17, 8'd0, 8'h00, A_FIX},   // 3  R10 absent id
    '{mk_lo(0,1,0,1,3'd0,8'h50), 8'h05, 8'd0, 8'h05, A_FIX},   // 4  R2 flat
    '{mk_lo(0,0,0,1,3'd0,8'h51), 8'h23, 8'd0, 8'h33, A_FIX},   // 5  R3 cluster
    '{mk_lo(0,0,0,1,3'd0,8'h52), 8'h28, 8'd0, 8'h08, A_FIX},   // 6  R2 flat only
    '{mk_lo(1,0,0,0,3'd4,8'h00), 8'h11, 8'd3, 8'h08, A_NMI},   // 7  R4 self
    '{mk_lo(2,0,0,0,3'd2,8'h00), 8'h11, 8'd3, 8'h7F, A_SMI},   // 8  R4 all
    '{mk_lo(3,0,0,0,3'd6,8'h9A), 8'h11, 8'd3, 8'h77, A_START}, // 9  R4 others
    '{mk_lo(0,0,0,1,3'd1,8'h60), 8'h0C, 8'd0, 8'h04, A_FIX},   // 10 R6 lowest
    '{mk_lo(2,0,1,0,3'd5,8'h00), 8'h00, 8'd0, 8'h7F, A_INIT},  // 11 R7 init
    '{mk_lo(2,1,0,0,3'd5,8'h00), 8'h00, 8'd0, 8'h7F, A_ARB},   // 12 R7 arbsync
    '{mk_lo(0,0,0,0,3'd5,8'h00), 8'h11, 8'd0, 8'h02, A_INIT},  // 13 R7 lvl0 trig0
    '{mk_lo(2,0,0,0,3'd3,8'h70), 8'h00, 8'd0, 8'h7F, A_NONE},  // 14 R9 mode 3
    '{mk_lo(0,0,0,0,3'd7,8'h71), 8'h10, 8'd0, 8'h01, A_NONE},  // 15 R9 mode 7
    '{mk_lo(3,0,0,0,3'd0,8'h72), 8'h00, 8'd7, 8'h7F, A_FIX},   // 16 R10 absent sender
    '{mk_lo(0,0,0,0,3'd0,8'h73), 8'h14, 8'd0, 8'h10, A_FIX}    // 17 R1 duplicate id
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1, 2, 17: return "R1";
      4, 6:        return "R2";
      5:           return "R3";
      7, 8, 9:     return "R4";
      10:          return "R6";
      11, 12, 13:  return "R7";
      14, 15:      return "R9";
      default:     return "R10";
    endcase
  endfunction

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_hi_we, cmd_lo_we;
  logic [31:0]      cmd_hi, cmd_lo;
  logic [7:0]       sender_id;
  logic [N-1:0]     agent_present;
  logic [N*8-1:0]   agent_phys_id, agent_log_id;
  logic [N*4-1:0]   agent_model;
  logic             res_valid, res_trigger;
  logic [7:0]       res_vector;
  logic [2:0]       res_mode;
  logic [N-1:0]     target_mask, fixed_mask, smi_mask, nmi_mask,
                    init_mask, startup_mask, arbsync_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_dest_resolver #(.N(N), .IDW(8)) u_dut (
    .clk, .rst_n, .cmd_hi_we, .cmd_hi, .cmd_lo_we, .cmd_lo, .sender_id,
    .agent_present, .agent_phys_id, .agent_log_id, .agent_model,
    .res_valid, .res_vector, .res_mode, .res_trigger, .target_mask,
    .fixed_mask, .smi_mask, .nmi_mask, .init_mask, .startup_mask, .arbsync_mask
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] lo, input logic [7:0] dest, input logic [7:0] snd);
    @(negedge clk);
    cmd_hi_we = 1'b1; cmd_hi = {dest, 24'h0};
    @(negedge clk);
    cmd_hi_we = 1'b0; cmd_hi = 32'h0;
    cmd_lo_we = 1'b1; cmd_lo = lo; sender_id = snd;
    @(negedge clk);
    cmd_lo_we = 1'b0;
  endtask

  task automatic check_actions(input string req, input logic [7:0] m, input logic [2:0] a);
    check(req, "fixed",   fixed_mask,   (a == A_FIX)   ? m : 8'h0);
    check(req, "smi",     smi_mask,     (a == A_SMI)   ? m : 8'h0);
    check(req, "nmi",     nmi_mask,     (a == A_NMI)   ? m : 8'h0);
    check(req, "init",    init_mask,    (a == A_INIT)  ? m : 8'h0);
    check(req, "startup", startup_mask, (a == A_START) ? m : 8'h0);
    check(req, "arbsync", arbsync_mask, (a == A_ARB)   ? m : 8'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_hi_we = 0; cmd_lo_we = 0; cmd_hi = 0; cmd_lo = 0; sender_id = 0;
    // agents 0..3 flat, 4..5 cluster, 6 unknown model, 7 absent
    agent_present = 8'h7F;
    agent_phys_id = {8'h17, 8'h16, 8'h14, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
    agent_log_id  = {8'hFF, 8'h23, 8'h22, 8'h21, 8'h08, 8'h04, 8'h02, 8'h01};
    agent_model   = {4'hF, 4'h5, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "valid in reset", res_valid, 0);
    check("R12", "mask in reset", target_mask, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "valid after reset", res_valid, 0);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].lo, TBL[i].dest, TBL[i].snd);
      check("R11", "valid", res_valid, 1);
      check(req_of(i), "target", target_mask, TBL[i].mask);
      check_actions(req_of(i), TBL[i].mask, TBL[i].act);
      check("R5", "vector", res_vector, TBL[i].lo[7:0]);
      check("R5", "mode", res_mode, TBL[i].lo[10:8]);
      check("R5", "trigger", res_trigger, TBL[i].lo[15]);
      @(negedge clk);
      check("R11", "pulse ended", res_valid, 0);
      check("R11", "mask cleared", target_mask, 0);
    end

    // R11 upper word alone gives no result
    @(negedge clk);
    cmd_hi_we = 1; cmd_hi = 32'h1000_0000;
    @(negedge clk);
    cmd_hi_we = 0;
    check("R11", "hi write only", res_valid, 0);
    // stored destination 0x10 is used by a later lower write
    @(negedge clk);
    cmd_lo_we = 1; cmd_lo = mk_lo(0,0,0,0,3'd0,8'h20);
    @(negedge clk);
    cmd_lo_we = 0;
    check("R11", "stored dest", target_mask, 8'h01);
    // R11 simultaneous upper write takes the new destination
    @(negedge clk);
    cmd_hi_we = 1; cmd_hi = 32'h1300_0000;
    cmd_lo_we = 1; cmd_lo = mk_lo(0,0,0,0,3'd0,8'h21);
    @(negedge clk);
    cmd_hi_we = 0; cmd_lo_we = 0;
    check("R11", "bypass dest", target_mask, 8'h08);
    // R10 removing an agent drops it from broadcast
    agent_present = 8'h3E;
    issue(mk_lo(0,0,0,0,3'd0,8'h22), 8'hFF, 8'd0);
    check("R10", "depopulated", target_mask, 8'h3E);
    // R12 reset mid-stream clears stored destination
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    agent_present = 8'h7F;
    @(negedge clk);
    cmd_lo_we = 1; cmd_lo = mk_lo(0,0,0,0,3'd0,8'h23);
    @(negedge clk);
    cmd_lo_we = 0;
    check("R12", "dest zero after reset", target_mask, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule